// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. A single free-running 64-bit main counter advances by one on every clock while the global enable is set. A parameterised set of comparator channels watches that counter. Each channel raises its own interrupt when the counter reaches the channel's comparator. A channel runs either once (one-shot) or repeatedly (periodic), and each channel can be routed by software. A legacy routing option moves channels 0 and 1 onto two fixed lines: a system-tick line and a real-time-clock line.

Software drives the timer over a plain 32-bit register port made of write strobe, read strobe, address and data. Read data is combinational while the read strobe is high. A periodic channel is loaded with a write sequence. Software sets the load-sequence flag in the channel config. The next comparator write then gives the first match value, and the write after that gives the reload period. Each channel also holds a message data/address register pair. This pair is only stored and read back, so an outer fabric can build interrupt messages from it.

Top module: `evt_timer`

## Requirements
- R1: The capability word at 0x000 reads {16'h0, legacy-capable at bit 15, 2'b0, channel count minus one in bits 12:8, revision 8'h01}, which is 0x0000_8201 with defaults. The word at 0x004 reads the tick period in femtoseconds (default 10,000,000).
- R2: While the global enable (bit 0 of 0x010) is set, the main counter grows by one per clock. While it is clear, the counter holds its value. The low word reads at 0xF0 and the high word at 0xF4.
- R3: Writes to 0xF0/0xF4 load the counter only while the global enable is clear. They are ignored while it is set.
- R4: A channel matches on the clock edge at which the counter equals its comparator, with the counter running. In one-shot mode the match sets the status bit exactly once and does not recur until a comparator word is written again.
- R5: Every match sets bit n of the status word at 0x020. Writing 1 to a status bit clears it. The channel interrupt output is that status bit ANDed with the channel enable.
- R6: Channel config lives at 0x100+0x20·n, with enable at bit 0, periodic at bit 1, load-sequence at bit 2, 32-bit compare at bit 3, route at bits 8:4, periodic-capable (read-only) at bit 16 and message-capable (read-only) at bit 17. In periodic mode, writing the load-sequence bit makes the next comparator write (0x108+0x20·n) the match value and the one after it the period. Each match then advances the comparator by that period.
- R7: On a channel whose periodic-capable bit is 0 (channels 1 and 2 by default), the periodic bit and the load-sequence bit read back 0. That channel behaves as one-shot and its comparator never advances.
- R8: With 32-bit compare set, only the low 32 bits of counter and comparator are compared. Without it, all 64 bits must be equal.
- R9: With the legacy bit (bit 1 of 0x010) set, channel 0's interrupt appears on the legacy tick line and channel 1's on the legacy RTC line, and both of their per-channel outputs stay low.
- R10: The route data (0x110+0x20·n) and route address (0x114+0x20·n) registers, and the comparator words, read back exactly the value last written, starting on the next read.
- R11: After reset, the counter, general config, status and all interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid while reg_rd_i is high |
| ch_irq_o | output | NUM_CH | Per-channel interrupt outputs |
| legacy_tick_irq_o | output | 1 | Legacy system-tick line (channel 0 when legacy routing is on) |
| legacy_rtc_irq_o | output | 1 | Legacy RTC line (channel 1 when legacy routing is on) |

## Verification
A register write takes effect at the edge that captures it, and a read returns the current state in the same cycle. The counter therefore shows its first increment one edge after the enable write. A comparator value C loaded while the counter stops at S raises the status bit at the (C−S+1)th edge after the enable write. The exact-timing checks sample status one edge before and on that edge. Periodic checks follow the same count: the second match falls one period later and the comparator readback has advanced by then. All other checks wait well past the due edge, or look at the outputs right after the write that changes them.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   // global register offsets
   localparam logic [11:0] A_CAP    = 12'h000;
   localparam logic [11:0] A_PERIOD = 12'h004;
   localparam logic [11:0] A_GCFG   = 12'h010;
   localparam logic [11:0] A_STAT   = 12'h020;
   localparam logic [11:0] A_CNT_LO = 12'h0F0;
   localparam logic [11:0] A_CNT_HI = 12'h0F4;

   // channel page 0x1xx, 32-byte stride
   localparam logic [3:0] CH_PAGE   = 4'h1;
   localparam logic [4:0] O_CFG     = 5'h00;
   localparam logic [4:0] O_CMP_LO  = 5'h08;
   localparam logic [4:0] O_CMP_HI  = 5'h0C;
   localparam logic [4:0] O_RT_DATA = 5'h10;
   localparam logic [4:0] O_RT_ADDR = 5'h14;

   // channel config field positions
   localparam int B_EN    = 0;
   localparam int B_PER   = 1;
   localparam int B_SET   = 2;
   localparam int B_F32   = 3;
   localparam int B_RT_LO = 4;
   localparam int RT_W    = 5;
   localparam int B_PCAP  = 16;
   localparam int B_MCAP  = 17;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_MATCH  = 2'd1,
      SEQ_PERIOD = 2'd2
   } ld_seq_e;

endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [31:0]      wdata_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int HI_W = CNT_W - 32;

   if (CNT_W <= 32 || CNT_W > 64) begin : g_bad_width
      $error("evt_main_counter: CNT_W must be in 33..64");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (wr_lo_i) begin
         cnt_q[31:0] <= wdata_i;
      end else if (wr_hi_i) begin
         cnt_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
      end
   end

   assign cnt_o = cnt_q;

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |=> cnt_o == $past(cnt_o) + 1'b1);

   // R3
   cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));

endmodule

// File: rtl/evt_channel.sv
module evt_channel
   import evt_timer_pkg::*;
#(
   parameter int CNT_W   = 64,
   parameter bit PER_CAP = 1'b0,
   parameter bit MSG_CAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             cfg_wr_i,
   input  logic             cmp_lo_wr_i,
   input  logic             cmp_hi_wr_i,
   input  logic             rtd_wr_i,
   input  logic             rta_wr_i,
   input  logic [31:0]      wdata_i,
   output logic [31:0]      cfg_rdata_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic [31:0]      rtd_o,
   output logic [31:0]      rta_o,
   output logic             match_o,
   output logic             en_o
);

   localparam int HI_W = CNT_W - 32;

   logic             en_q, per_q, f32_q, armed_q;
   logic [RT_W-1:0]  rt_q;
   ld_seq_e          seq_q;
   logic [CNT_W-1:0] cmp_q, prd_q, cmp_adv;
   logic [31:0]      rtd_q, rta_q;

   assign match_o = run_i && armed_q &&
                    (f32_q ? (cnt_i[31:0] == cmp_q[31:0]) : (cnt_i == cmp_q));

   always_comb begin
      if (f32_q) cmp_adv = {cmp_q[CNT_W-1:32], cmp_q[31:0] + prd_q[31:0]};
      else       cmp_adv = cmp_q + prd_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         per_q   <= 1'b0;
         f32_q   <= 1'b0;
         armed_q <= 1'b0;
         rt_q    <= '0;
         seq_q   <= SEQ_IDLE;
         cmp_q   <= '0;
         prd_q   <= '0;
         rtd_q   <= '0;
         rta_q   <= '0;
      end else begin
         if (cfg_wr_i) begin
            en_q  <= wdata_i[B_EN];
            per_q <= wdata_i[B_PER] & PER_CAP;
            f32_q <= wdata_i[B_F32];
            rt_q  <= wdata_i[B_RT_LO +: RT_W];
            if (wdata_i[B_SET] && wdata_i[B_PER] && PER_CAP) seq_q <= SEQ_MATCH;
         end
         if (rtd_wr_i) rtd_q <= wdata_i;
         if (rta_wr_i) rta_q <= wdata_i;
         if (cmp_lo_wr_i) begin
            if (seq_q == SEQ_PERIOD) begin
               prd_q[31:0] <= wdata_i;
               seq_q       <= SEQ_IDLE;
            end else begin
               cmp_q[31:0] <= wdata_i;
               armed_q     <= 1'b1;
               if (seq_q == SEQ_MATCH) seq_q <= SEQ_PERIOD;
            end
         end else if (cmp_hi_wr_i) begin
            if (seq_q == SEQ_PERIOD) begin
               prd_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
            end else begin
               cmp_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
               armed_q           <= 1'b1;
            end
         end else if (match_o) begin
            if (per_q) cmp_q   <= cmp_adv;
            else       armed_q <= 1'b0;
         end
      end
   end

   always_comb begin
      cfg_rdata_o                        = '0;
      cfg_rdata_o[B_EN]                  = en_q;
      cfg_rdata_o[B_PER]                 = per_q;
      cfg_rdata_o[B_SET]                 = (seq_q != SEQ_IDLE);
      cfg_rdata_o[B_F32]                 = f32_q;
      cfg_rdata_o[B_RT_LO +: RT_W]       = rt_q;
      cfg_rdata_o[B_PCAP]                = PER_CAP;
      cfg_rdata_o[B_MCAP]                = MSG_CAP;
   end

   assign cmp_o = cmp_q;
   assign rtd_o = rtd_q;
   assign rta_o = rta_q;
   assign en_o  = en_q;

   // R4
   oneshot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !per_q && !cmp_lo_wr_i && !cmp_hi_wr_i) |=> !match_o);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int                NUM_CH       = 3,
   parameter int                CNT_W        = 64,
   parameter logic [31:0]       TICK_FS      = 32'd10_000_000,
   parameter bit                LEGACY_CAP   = 1'b1,
   parameter logic [NUM_CH-1:0] PER_CAP_MASK = NUM_CH'(1),
   parameter logic [NUM_CH-1:0] MSG_CAP_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [11:0]       reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic [NUM_CH-1:0] ch_irq_o,
   output logic              legacy_tick_irq_o,
   output logic              legacy_rtc_irq_o
);

   localparam int         IDX_W   = 3;
   localparam logic [4:0] CH_LAST = 5'(NUM_CH - 1);

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_count
      $error("evt_timer: NUM_CH must be in 1..8");
   end
   if (LEGACY_CAP && NUM_CH < 2) begin : g_bad_legacy
      $error("evt_timer: legacy routing needs at least two channels");
   end

   logic              gen_en_q, leg_q;
   logic [NUM_CH-1:0] stat_q, ch_match, ch_en, w1c_mask;
   logic [CNT_W-1:0]  cnt;
   logic              on_page;
   logic [IDX_W-1:0]  ch_idx;
   logic [4:0]        ch_off;

   logic [31:0]       ch_cfg_rd [NUM_CH];
   logic [CNT_W-1:0]  ch_cmp    [NUM_CH];
   logic [31:0]       ch_rtd    [NUM_CH];
   logic [31:0]       ch_rta    [NUM_CH];

   assign on_page = (reg_addr_i[11:8] == CH_PAGE);
   assign ch_idx  = reg_addr_i[7:5];
   assign ch_off  = reg_addr_i[4:0];

   assign w1c_mask = (reg_wr_i && reg_addr_i == A_STAT) ? reg_wdata_i[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en_q <= 1'b0;
         leg_q    <= 1'b0;
         stat_q   <= '0;
      end else begin
         if (reg_wr_i && reg_addr_i == A_GCFG) begin
            gen_en_q <= reg_wdata_i[0];
            leg_q    <= reg_wdata_i[1] & LEGACY_CAP;
         end
         stat_q <= (stat_q & ~w1c_mask) | ch_match;
      end
   end

   evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (gen_en_q),
      .wr_lo_i (reg_wr_i && reg_addr_i == A_CNT_LO && !gen_en_q),
      .wr_hi_i (reg_wr_i && reg_addr_i == A_CNT_HI && !gen_en_q),
      .wdata_i (reg_wdata_i),
      .cnt_o   (cnt)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel;
      assign sel = reg_wr_i && on_page && (ch_idx == IDX_W'(g));

      evt_channel #(
         .CNT_W   (CNT_W),
         .PER_CAP (PER_CAP_MASK[g]),
         .MSG_CAP (MSG_CAP_MASK[g])
      ) u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .run_i       (gen_en_q),
         .cnt_i       (cnt),
         .cfg_wr_i    (sel && ch_off == O_CFG),
         .cmp_lo_wr_i (sel && ch_off == O_CMP_LO),
         .cmp_hi_wr_i (sel && ch_off == O_CMP_HI),
         .rtd_wr_i    (sel && ch_off == O_RT_DATA),
         .rta_wr_i    (sel && ch_off == O_RT_ADDR),
         .wdata_i     (reg_wdata_i),
         .cfg_rdata_o (ch_cfg_rd[g]),
         .cmp_o       (ch_cmp[g]),
         .rtd_o       (ch_rtd[g]),
         .rta_o       (ch_rta[g]),
         .match_o     (ch_match[g]),
         .en_o        (ch_en[g])
      );

      if (g < 2 && LEGACY_CAP) begin : g_muted
         assign ch_irq_o[g] = stat_q[g] & ch_en[g] & ~leg_q;
      end else begin : g_plain
         assign ch_irq_o[g] = stat_q[g] & ch_en[g];
      end

      // R5
      status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_q[g]) |-> $past(ch_match[g]));
   end

   if (LEGACY_CAP) begin : g_leg
      assign legacy_tick_irq_o = leg_q & stat_q[0] & ch_en[0];
      assign legacy_rtc_irq_o  = leg_q & stat_q[1] & ch_en[1];

      // R9
      legacy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (legacy_tick_irq_o || legacy_rtc_irq_o) |-> (ch_irq_o[1:0] == 2'b00));
   end else begin : g_no_leg
      assign legacy_tick_irq_o = 1'b0;
      assign legacy_rtc_irq_o  = 1'b0;
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_rd_i) begin
         case (reg_addr_i)
            A_CAP:    reg_rdata_o = {16'h0, LEGACY_CAP, 2'b00, CH_LAST, 8'h01};
            A_PERIOD: reg_rdata_o = TICK_FS;
            A_GCFG:   reg_rdata_o = {30'b0, leg_q, gen_en_q};
            A_STAT:   reg_rdata_o = 32'(stat_q);
            A_CNT_LO: reg_rdata_o = cnt[31:0];
            A_CNT_HI: reg_rdata_o = 32'(cnt[CNT_W-1:32]);
            default: begin
               for (int i = 0; i < NUM_CH; i++) begin
                  if (on_page && ch_idx == IDX_W'(i)) begin
                     case (ch_off)
                        O_CFG:     reg_rdata_o = ch_cfg_rd[i];
                        O_CMP_LO:  reg_rdata_o = ch_cmp[i][31:0];
                        O_CMP_HI:  reg_rdata_o = 32'(ch_cmp[i][CNT_W-1:32]);
                        O_RT_DATA: reg_rdata_o = ch_rtd[i];
                        O_RT_ADDR: reg_rdata_o = ch_rta[i];
                        default:   reg_rdata_o = '0;
                     endcase
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: tb/evt_timer_tb.sv
module evt_timer_tb;

   localparam int CLK_NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  ch_irq;
   logic        leg_tick, leg_rtc;

   int total = 0;
   int bad   = 0;

   always #(CLK_NS/2) clk = ~clk;

   evt_timer u_dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .reg_wr_i          (reg_wr),
      .reg_rd_i          (reg_rd),
      .reg_addr_i        (reg_addr),
      .reg_wdata_i       (reg_wdata),
      .reg_rdata_o       (reg_rdata),
      .ch_irq_o          (ch_irq),
      .legacy_tick_irq_o (leg_tick),
      .legacy_rtc_irq_o  (leg_rtc)
   );

   // {address, write data, expected readback}
   localparam logic [75:0] VEC [9] = '{
      {12'h110, 32'hDEADBEEF, 32'hDEADBEEF},
      {12'h114, 32'hFEE01000, 32'hFEE01000},
      {12'h130, 32'h12345678, 32'h12345678},
      {12'h154, 32'hA5A5A5A5, 32'hA5A5A5A5},
      {12'h108, 32'h00001234, 32'h00001234},
      {12'h10C, 32'h00000007, 32'h00000007},
      {12'h140, 32'h0000000B, 32'h00020009},
      {12'h100, 32'h000000F1, 32'h000300F1},
      {12'h120, 32'h00000000, 32'h00020000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // all tasks start and end 1 ns after a rising edge
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a; reg_rd = 1'b1;
      #1;
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   initial begin : wdog
      #(CLK_NS * 100000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      tick(4);
      rst_n = 1'b1;
      tick(1);

      // R11 reset state
      rd(12'h0F0, d); chk("R11 counter lo", d, 0);
      rd(12'h010, d); chk("R11 gcfg", d, 0);
      rd(12'h020, d); chk("R11 status", d, 0);
      chk("R11 irqs", {ch_irq, leg_tick, leg_rtc}, 0);

      // R1 capability and period
      rd(12'h000, d); chk("R1 capability", d, 32'h0000_8201);
      rd(12'h004, d); chk("R1 period", d, 32'd10_000_000);

      // R10 / R7 table walk
      for (int i = 0; i < 9; i++) begin
         wr(VEC[i][75:64], VEC[i][63:32]);
         rd(VEC[i][75:64], d);
         chk($sformatf("R10 R7 table vector %0d", i), d, VEC[i][31:0]);
      end

      // R3 load while stopped, ignore while running; R2 counting
      wr(12'h0F0, 32'd100); wr(12'h0F4, 32'd0);
      rd(12'h0F0, d); chk("R3 load when stopped", d, 100);
      wr(12'h010, 32'h1);           // E0
      wr(12'h0F0, 32'd5);           // E1, ignored
      rd(12'h0F0, d); chk("R3 write ignored while running", d, 101);
      tick(9);
      rd(12'h0F0, d); chk("R2 counting", d, 110);
      wr(12'h010, 32'h0);
      rd(12'h0F0, d); chk("R2 stop value", d, 111);
      tick(3);
      rd(12'h0F0, d); chk("R2 hold while stopped", d, 111);
      rd(12'h0F4, d); chk("R2 high word", d, 0);

      // R4 exact one-shot timing on channel 1
      wr(12'h0F0, 32'd200);
      wr(12'h128, 32'd205); wr(12'h12C, 32'd0);
      wr(12'h120, 32'h1);
      wr(12'h020, 32'h7);
      wr(12'h010, 32'h1);           // E0
      tick(5);
      rd(12'h020, d); chk("R4 no match before due edge", d[1], 0);
      tick(1);
      rd(12'h020, d); chk("R4 match on due edge", d[1], 1);
      chk("R5 irq follows status", ch_irq[1], 1);
      wr(12'h010, 32'h0);
      wr(12'h0F0, 32'd200);
      wr(12'h020, 32'h2);
      rd(12'h020, d); chk("R5 write-one clears", d[1], 0);
      wr(12'h010, 32'h1);
      tick(10);
      rd(12'h020, d); chk("R4 no refire without rewrite", d[1], 0);

      // R5 gating by channel enable
      wr(12'h010, 32'h0);
      wr(12'h0F0, 32'd300);
      wr(12'h120, 32'h0);
      wr(12'h128, 32'd303);
      wr(12'h020, 32'h7);
      wr(12'h010, 32'h1);
      tick(10);
      rd(12'h020, d); chk("R5 status set on disabled channel", d[1], 1);
      chk("R5 irq masked when disabled", ch_irq[1], 0);
      wr(12'h120, 32'h1);
      chk("R5 irq after enable", ch_irq[1], 1);
      wr(12'h020, 32'h2);
      chk("R5 irq drops on clear", ch_irq[1], 0);

      // R6 periodic sequence on channel 0
      wr(12'h010, 32'h0);
      wr(12'h0F0, 32'd1000); wr(12'h0F4, 32'd0);
      wr(12'h10C, 32'd0);
      wr(12'h100, 32'h7);
      wr(12'h108, 32'd1010);
      wr(12'h108, 32'd20);
      rd(12'h108, d); chk("R6 match value kept", d, 1010);
      wr(12'h020, 32'h7);
      wr(12'h010, 32'h1);           // E0
      tick(11);
      rd(12'h020, d); chk("R6 first periodic match", d[0], 1);
      wr(12'h020, 32'h1);           // E12
      tick(18);
      rd(12'h020, d); chk("R6 quiet before next period", d[0], 0);
      tick(1);
      rd(12'h020, d); chk("R6 second periodic match", d[0], 1);
      rd(12'h108, d); chk("R6 comparator advanced", d, 1050);

      // R7 periodic request ignored on channel 2
      wr(12'h010, 32'h0);
      wr(12'h140, 32'h7);
      rd(12'h140, d); chk("R7 periodic and sequence bits read 0", d, 32'h0002_0001);
      wr(12'h0F0, 32'd2000);
      wr(12'h148, 32'd2005); wr(12'h14C, 32'd0);
      rd(12'h148, d); chk("R10 comparator readback", d, 2005);
      wr(12'h020, 32'h7);
      wr(12'h010, 32'h1);
      tick(30);
      rd(12'h020, d); chk("R7 one-shot match", d[2], 1);
      rd(12'h148, d); chk("R7 comparator not advanced", d, 2005);
      wr(12'h020, 32'h4);
      tick(30);
      rd(12'h020, d); chk("R7 no second match", d[2], 0);

      // R8 32-bit compare on channel 1
      wr(12'h010, 32'h0);
      wr(12'h0F0, 32'h50); wr(12'h0F4, 32'h1);
      wr(12'h128, 32'h55); wr(12'h12C, 32'h5);
      wr(12'h120, 32'h1);
      wr(12'h020, 32'h7);
      wr(12'h010, 32'h1);
      tick(10);
      rd(12'h020, d); chk("R8 full compare misses", d[1], 0);
      wr(12'h010, 32'h0);
      wr(12'h0F0, 32'h50);
      wr(12'h128, 32'h55);
      wr(12'h120, 32'h9);
      wr(12'h020, 32'h7);
      wr(12'h010, 32'h1);
      tick(10);
      rd(12'h020, d); chk("R8 low-word compare hits", d[1], 1);

      // R9 legacy routing
      wr(12'h010, 32'h0);
      wr(12'h0F0, 32'd3000); wr(12'h0F4, 32'd0);
      wr(12'h100, 32'h1);
      wr(12'h108, 32'd3002); wr(12'h10C, 32'd0);
      wr(12'h120, 32'h1);
      wr(12'h128, 32'd3004); wr(12'h12C, 32'd0);
      wr(12'h020, 32'h7);
      wr(12'h010, 32'h3);
      tick(10);
      chk("R9 legacy lines active", {leg_tick, leg_rtc}, 2'b11);
      chk("R9 channel outputs muted", ch_irq, 3'b000);
      wr(12'h010, 32'h1);
      chk("R9 legacy off restores channels", {ch_irq, leg_tick, leg_rtc}, 5'b01100);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule